// File: doc/BRIEF.md
# ECC Error Status and Threshold Manager

This block sits beside the check logic of a memory read path. It turns the per-read error pulses from that logic into a small bank of status registers that software reads and writes. There are three error classes: single-bit, multi-bit and memory-select. Each class has its own interrupt enable and its own disable bit. Single-bit errors are counted against a programmable threshold. Each class raises a sticky detect flag, and a second event on a class whose flag is already set raises a shared multiple-errors flag. The first failing read is captured in full: its address, data words, check byte and transaction attributes.

Software uses a plain word-addressed register port with byte strobes. Writes take effect at the next clock edge, and read data follows the address combinationally. The interrupt output is a level that stays high while any enabled detect flag is set.

Top module: `ecc_err_mgr`

## Requirements
- R1: Out of reset, the enable register (word 0) and the disable register (word 1) read 0. The counter register (word 2) reads 0x0000FF00, meaning threshold 255 and count 0. The detect register (word 3) reads 0, every capture register reads 0, and irq_o is low.
- R2: Word 2 holds the single-bit count in bits [7:0] and the threshold in bits [15:8]. A write whose byte strobe selects only one of those bytes changes only that field.
- R3: An enabled single-bit error adds one to the count. If the new count is still below the threshold, detect bit 0 is left unchanged.
- R4: When an enabled single-bit error brings the count up to the threshold, detect bit 0 (single-bit) is set and the count returns to 0.
- R5: An enabled multi-bit error sets detect bit 1. An enabled memory-select error sets detect bit 2.
- R6: Detect bit 3 (multiple errors) is set when a class event occurs while that class's detect bit is already set. For the single-bit class, the event is reaching the threshold.
- R7: Writing 1 to detect bits clears them, and any combination can be cleared in one write. If a hardware event sets a bit in the same cycle that software clears it, the bit ends up set.
- R8: Disable register bits 0, 1 and 2 mask the single-bit, multi-bit and memory-select classes. A masked event changes neither the count, the detect flags nor the capture registers.
- R9: An enabled event captures the read while the valid bit is clear. The captured values are: address in word 4, data[63:32] in word 5, data[31:0] in word 6, check byte in word 7 bits [7:0], and attributes in word 8. Word 8 carries valid in bit 0, beat in [3:1], size in [5:4], source in [10:6] and type in [12:11].
- R10: While the valid bit is set, later events leave every capture register unchanged. Writing 0 to word 8 rearms capture.
- R11: irq_o is high exactly when one of detect bits 0..2 is set together with the matching bit of the enable register. Detect bit 3 does not drive irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_sbe_i | input | 1 | Single-bit error pulse for the current read |
| err_mbe_i | input | 1 | Multi-bit error pulse |
| err_mse_i | input | 1 | Memory-select error pulse |
| err_addr_i | input | 32 | Address of the failing read |
| err_data_i | input | 64 | Data of the failing read |
| err_chk_i | input | 8 | Check byte of the failing read |
| err_beat_i | input | 3 | Data beat number |
| err_size_i | input | 2 | Transaction size |
| err_src_i | input | 5 | Transaction source |
| err_type_i | input | 2 | Transaction type |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_be_i | input | 4 | Byte strobes for writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt level |

## Verification
The bench builds the block with its default widths: an 8-bit count and threshold, a 32-bit address and a 64-bit data word. Several scenarios program a threshold of 3, so a wrap and a repeated wrap take only a handful of pulses. One scenario keeps the full reset threshold of 255, which reaches the top-of-range boundary in a few hundred cycles. The same-cycle clear-versus-set collision and the one-hot byte-strobe writes are driven on purpose.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int unsigned NCLS    = 3;
  localparam int unsigned CLS_SBE = 0;
  localparam int unsigned CLS_MBE = 1;
  localparam int unsigned CLS_MSE = 2;
  localparam int unsigned DET_MME = 3;

  localparam logic [3:0] A_IEN   = 4'd0;
  localparam logic [3:0] A_DIS   = 4'd1;
  localparam logic [3:0] A_SBE   = 4'd2;
  localparam logic [3:0] A_DET   = 4'd3;
  localparam logic [3:0] A_CADDR = 4'd4;
  localparam logic [3:0] A_CDHI  = 4'd5;
  localparam logic [3:0] A_CDLO  = 4'd6;
  localparam logic [3:0] A_CCHK  = 4'd7;
  localparam logic [3:0] A_CATTR = 4'd8;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] merge_w(input logic [31:0] old_v,
                                          input logic [31:0] wd,
                                          input logic [3:0]  be);
    return (old_v & ~be_mask(be)) | (wd & be_mask(be));
  endfunction
endpackage

// File: rtl/ecc_sbe_ctr.sv
module ecc_sbe_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_i,
  input  logic               wr_i,
  input  logic [2*CNT_W-1:0] wdata_i,
  output logic               reach_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   thr_o
);
  logic [CNT_W-1:0] cnt_q, thr_q;
  logic [CNT_W:0]   sum;

  assign sum     = {1'b0, cnt_q} + 1'b1;
  // software write owns the register in its cycle
  assign reach_o = ev_i & ~wr_i & (sum >= {1'b0, thr_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      thr_q <= '1;
    end else if (wr_i) begin
      {thr_q, cnt_q} <= wdata_i;
    end else if (ev_i) begin
      cnt_q <= reach_o ? '0 : sum[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/ecc_det_flags.sv
module ecc_det_flags #(
  parameter int unsigned NCLS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NCLS-1:0] set_i,
  input  logic [NCLS:0]   clr_i,
  output logic [NCLS:0]   flags_o
);
  logic [NCLS:0] flag_q;
  logic          mme_set;

  assign mme_set = |(set_i & flag_q[NCLS-1:0]);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[c] <= 1'b0;
      else         flag_q[c] <= set_i[c] | (flag_q[c] & ~clr_i[c]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q[NCLS] <= 1'b0;
    else         flag_q[NCLS] <= mme_set | (flag_q[NCLS] & ~clr_i[NCLS]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8,
  parameter int unsigned ATTR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [4:0]        wr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [HALF_W-1:0] dhi_o,
  output logic [HALF_W-1:0] dlo_o,
  output logic [CHK_W-1:0]  chk_o,
  output logic [ATTR_W:0]   attr_o
);
  import ecc_err_pkg::*;
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic [HALF_W-1:0] dhi_q, dlo_q;
  logic [CHK_W-1:0]  chk_q;
  logic [ATTR_W:0]   attr_q;
  logic              load;
  logic [31:0]       m_addr, m_dhi, m_dlo, m_chk, m_attr;

  assign load   = ev_i & ~attr_q[0];
  assign m_addr = merge_w(32'(addr_q), wdata_i, be_i);
  assign m_dhi  = merge_w(32'(dhi_q),  wdata_i, be_i);
  assign m_dlo  = merge_w(32'(dlo_q),  wdata_i, be_i);
  assign m_chk  = merge_w(32'(chk_q),  wdata_i, be_i);
  assign m_attr = merge_w(32'(attr_q), wdata_i, be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dhi_q  <= '0;
      dlo_q  <= '0;
      chk_q  <= '0;
      attr_q <= '0;
    end else begin
      if (wr_i[0])   addr_q <= m_addr[ADDR_W-1:0];
      else if (load) addr_q <= addr_i;
      if (wr_i[1])   dhi_q  <= m_dhi[HALF_W-1:0];
      else if (load) dhi_q  <= data_i[DATA_W-1:HALF_W];
      if (wr_i[2])   dlo_q  <= m_dlo[HALF_W-1:0];
      else if (load) dlo_q  <= data_i[HALF_W-1:0];
      if (wr_i[3])   chk_q  <= m_chk[CHK_W-1:0];
      else if (load) chk_q  <= chk_i;
      if (wr_i[4])   attr_q <= m_attr[ATTR_W:0];
      else if (load) attr_q <= {attr_i, 1'b1};
    end
  end

  assign addr_o = addr_q;
  assign dhi_o  = dhi_q;
  assign dlo_o  = dlo_q;
  assign chk_o  = chk_q;
  assign attr_o = attr_q;
endmodule

// File: rtl/ecc_err_mgr.sv
module ecc_err_mgr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned BEAT_W = 3,
  parameter int unsigned SIZE_W = 2,
  parameter int unsigned SRC_W  = 5,
  parameter int unsigned TYPE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_sbe_i,
  input  logic              err_mbe_i,
  input  logic              err_mse_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic [CHK_W-1:0]  err_chk_i,
  input  logic [BEAT_W-1:0] err_beat_i,
  input  logic [SIZE_W-1:0] err_size_i,
  input  logic [SRC_W-1:0]  err_src_i,
  input  logic [TYPE_W-1:0] err_type_i,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [3:0]        reg_be_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  import ecc_err_pkg::*;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned ATTR_W = BEAT_W + SIZE_W + SRC_W + TYPE_W;

  logic [NCLS-1:0]   ien_q, dis_q, raw_ev, ev, set_req;
  logic [NCLS:0]     det_q, det_clr;
  logic [CNT_W-1:0]  cnt_q, thr_q;
  logic              reach, wr_sbe;
  logic [31:0]       m_ien, m_dis, m_sbe, wmask;
  logic [4:0]        wr_cap;
  logic [ADDR_W-1:0] cap_addr;
  logic [HALF_W-1:0] cap_dhi, cap_dlo;
  logic [CHK_W-1:0]  cap_chk;
  logic [ATTR_W:0]   cap_attr;
  logic              cap_valid;

  assign raw_ev = {err_mse_i, err_mbe_i, err_sbe_i};
  assign ev     = raw_ev & ~dis_q;
  assign wmask  = be_mask(reg_be_i);

  assign m_ien  = merge_w(32'(ien_q), reg_wdata_i, reg_be_i);
  assign m_dis  = merge_w(32'(dis_q), reg_wdata_i, reg_be_i);
  assign m_sbe  = merge_w(32'({thr_q, cnt_q}), reg_wdata_i, reg_be_i);
  assign wr_sbe = reg_we_i && (reg_addr_i == A_SBE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      dis_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_IEN) ien_q <= m_ien[NCLS-1:0];
      if (reg_addr_i == A_DIS) dis_q <= m_dis[NCLS-1:0];
    end
  end

  ecc_sbe_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev[CLS_SBE]),
    .wr_i    (wr_sbe),
    .wdata_i (m_sbe[2*CNT_W-1:0]),
    .reach_o (reach),
    .cnt_o   (cnt_q),
    .thr_o   (thr_q)
  );

  always_comb begin
    set_req          = ev;
    set_req[CLS_SBE] = reach;
  end

  assign det_clr = (reg_we_i && (reg_addr_i == A_DET)) ?
                   (reg_wdata_i[NCLS:0] & wmask[NCLS:0]) : '0;

  ecc_det_flags #(.NCLS(NCLS)) u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_req),
    .clr_i   (det_clr),
    .flags_o (det_q)
  );

  for (genvar k = 0; k < 5; k++) begin : g_capwr
    assign wr_cap[k] = reg_we_i && (reg_addr_i == A_CADDR + 4'(k));
  end

  ecc_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .ATTR_W (ATTR_W)
  ) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (|ev),
    .addr_i  (err_addr_i),
    .data_i  (err_data_i),
    .chk_i   (err_chk_i),
    .attr_i  ({err_type_i, err_src_i, err_size_i, err_beat_i}),
    .wr_i    (wr_cap),
    .be_i    (reg_be_i),
    .wdata_i (reg_wdata_i),
    .addr_o  (cap_addr),
    .dhi_o   (cap_dhi),
    .dlo_o   (cap_dlo),
    .chk_o   (cap_chk),
    .attr_o  (cap_attr)
  );

  assign cap_valid = cap_attr[0];

  always_comb begin
    unique case (reg_addr_i)
      A_IEN:   reg_rdata_o = 32'(ien_q);
      A_DIS:   reg_rdata_o = 32'(dis_q);
      A_SBE:   reg_rdata_o = 32'({thr_q, cnt_q});
      A_DET:   reg_rdata_o = 32'(det_q);
      A_CADDR: reg_rdata_o = 32'(cap_addr);
      A_CDHI:  reg_rdata_o = 32'(cap_dhi);
      A_CDLO:  reg_rdata_o = 32'(cap_dlo);
      A_CCHK:  reg_rdata_o = 32'(cap_chk);
      A_CATTR: reg_rdata_o = 32'(cap_attr);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(det_q[NCLS-1:0] & ien_q);
endmodule

// File: rtl/ecc_err_mgr_chk.sv
module ecc_err_mgr_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_sbe_i,
  input logic              err_mbe_i,
  input logic              err_mse_i,
  input logic              reg_we_i,
  input logic              irq_o,
  input logic [2:0]        ien_q,
  input logic [2:0]        dis_q,
  input logic [3:0]        det_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  thr_q,
  input logic              cap_valid,
  input logic [ADDR_W-1:0] cap_addr
);
  // R3
  sbe_below_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_sbe_i && !dis_q[0] && !reg_we_i &&
     (({1'b0, cnt_q} + 1'b1) < {1'b0, thr_q}))
    |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && (det_q[0] == $past(det_q[0])));

  // R5
  mbe_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_mbe_i && !dis_q[1]) |=> det_q[1]);

  // R6
  mme_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_mse_i && !dis_q[2] && det_q[2]) |=> det_q[3]);

  // R8
  masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_mbe_i && dis_q[1] && !err_sbe_i && !err_mse_i && !reg_we_i)
    |=> $stable(det_q) && $stable(cap_valid));

  // R10
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid && !reg_we_i) |=> $stable(cap_addr) && cap_valid);

  // R11
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == 3'b000) |-> !irq_o);
endmodule

bind ecc_err_mgr ecc_err_mgr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .err_sbe_i (err_sbe_i),
  .err_mbe_i (err_mbe_i),
  .err_mse_i (err_mse_i),
  .reg_we_i  (reg_we_i),
  .irq_o     (irq_o),
  .ien_q     (ien_q),
  .dis_q     (dis_q),
  .det_q     (det_q),
  .cnt_q     (cnt_q),
  .thr_q     (thr_q),
  .cap_valid (cap_valid),
  .cap_addr  (cap_addr)
);

// File: tb/ecc_err_mgr_test.sv
module ecc_err_mgr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbe = 0, mbe = 0, mse = 0;
  logic [31:0] e_addr = '0;
  logic [63:0] e_data = '0;
  logic [7:0]  e_chk = '0;
  logic [2:0]  e_beat = '0;
  logic [1:0]  e_size = '0;
  logic [4:0]  e_src = '0;
  logic [1:0]  e_type = '0;
  logic        we = 0;
  logic [3:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_mgr uut (
    .clk_i(clk), .rst_ni(rst_n),
    .err_sbe_i(sbe), .err_mbe_i(mbe), .err_mse_i(mse),
    .err_addr_i(e_addr), .err_data_i(e_data), .err_chk_i(e_chk),
    .err_beat_i(e_beat), .err_size_i(e_size), .err_src_i(e_src), .err_type_i(e_type),
    .reg_we_i(we), .reg_addr_i(addr), .reg_be_i(be), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    we = 0; be = '0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input logic [2:0] cls);
    @(negedge clk);
    {mse, mbe, sbe} = cls;
    @(negedge clk);
    {mse, mbe, sbe} = 3'b000;
  endtask

  task automatic set_fields(input logic [31:0] a, input logic [63:0] d, input logic [7:0] c,
                            input logic [2:0] bt, input logic [1:0] sz,
                            input logic [4:0] sr, input logic [1:0] ty);
    e_addr = a; e_data = d; e_chk = c; e_beat = bt; e_size = sz; e_src = sr; e_type = ty;
  endtask

  function automatic logic [31:0] attr_word(input logic [2:0] bt, input logic [1:0] sz,
                                            input logic [4:0] sr, input logic [1:0] ty);
    return 32'(1) | (32'(bt) << 1) | (32'(sz) << 4) | (32'(sr) << 6) | (32'(ty) << 11);
  endfunction

  task automatic t_reset;
    expect_reg("R1 ien", 4'd0, 32'h0);
    expect_reg("R1 dis", 4'd1, 32'h0);
    expect_reg("R1 sbe mgmt", 4'd2, 32'h0000_FF00);
    expect_reg("R1 detect", 4'd3, 32'h0);
    for (int k = 4; k <= 8; k++) expect_reg("R1 capture", 4'(k), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_fields;
    reg_wr(4'd2, 32'hDEAD_0300, 4'b0010);
    expect_reg("R2 thr only", 4'd2, 32'h0000_0300);
    reg_wr(4'd2, 32'hAAAA_BB01, 4'b0001);
    expect_reg("R2 cnt only", 4'd2, 32'h0000_0301);
    reg_wr(4'd2, 32'h0, 4'b0001);
  endtask

  task automatic t_threshold;
    pulse(3'b001);
    expect_reg("R3 cnt 1", 4'd2, 32'h0000_0301);
    expect_reg("R3 no flag", 4'd3, 32'h0);
    pulse(3'b001);
    expect_reg("R3 cnt 2", 4'd2, 32'h0000_0302);
    expect_reg("R3 still no flag", 4'd3, 32'h0);
    pulse(3'b001);
    expect_reg("R4 wrap", 4'd2, 32'h0000_0300);
    expect_reg("R4 flag", 4'd3, 32'h1);
    repeat (3) pulse(3'b001);
    expect_reg("R6 second reach", 4'd3, 32'h9);
    reg_wr(4'd3, 32'hF, 4'b0001);
    expect_reg("R7 clear all", 4'd3, 32'h0);
  endtask

  task automatic t_classes;
    pulse(3'b010);
    expect_reg("R5 mbe", 4'd3, 32'h2);
    pulse(3'b010);
    expect_reg("R6 mbe repeat", 4'd3, 32'hA);
    reg_wr(4'd3, 32'h8, 4'b0001);
    expect_reg("R7 clear mme only", 4'd3, 32'h2);
    pulse(3'b100);
    expect_reg("R5 mse", 4'd3, 32'h6);
    reg_wr(4'd3, 32'h6, 4'b0001);
    expect_reg("R7 clear pair", 4'd3, 32'h0);
    pulse(3'b010);
    @(negedge clk);
    we = 1; addr = 4'd3; wdata = 32'h2; be = 4'b0001; mbe = 1;
    @(negedge clk);
    we = 0; be = '0; mbe = 0;
    expect_reg("R7 set wins", 4'd3, 32'hA);
    reg_wr(4'd3, 32'hF, 4'b0001);
  endtask

  task automatic t_disable;
    reg_wr(4'd8, 32'h0, 4'b1111);
    reg_wr(4'd1, 32'h7, 4'b0001);
    pulse(3'b111);
    pulse(3'b001);
    expect_reg("R8 no flags", 4'd3, 32'h0);
    expect_reg("R8 cnt held", 4'd2, 32'h0000_0300);
    expect_reg("R8 no capture", 4'd8, 32'h0);
    reg_wr(4'd1, 32'h0, 4'b0001);
  endtask

  task automatic t_capture;
    set_fields(32'h0012_3450, 64'h1122_3344_5566_7788, 8'h5A, 3'd3, 2'd2, 5'h11, 2'd1);
    pulse(3'b100);
    expect_reg("R9 addr", 4'd4, 32'h0012_3450);
    expect_reg("R9 data hi", 4'd5, 32'h1122_3344);
    expect_reg("R9 data lo", 4'd6, 32'h5566_7788);
    expect_reg("R9 chk", 4'd7, 32'h5A);
    expect_reg("R9 attr", 4'd8, attr_word(3'd3, 2'd2, 5'h11, 2'd1));
    set_fields(32'h0ABC_0008, 64'hCAFE_0000_0000_BEEF, 8'hC3, 3'd6, 2'd1, 5'h0A, 2'd2);
    pulse(3'b010);
    expect_reg("R10 addr held", 4'd4, 32'h0012_3450);
    expect_reg("R10 chk held", 4'd7, 32'h5A);
    reg_wr(4'd8, 32'h0, 4'b1111);
    pulse(3'b010);
    expect_reg("R10 rearm addr", 4'd4, 32'h0ABC_0008);
    expect_reg("R10 rearm hi", 4'd5, 32'hCAFE_0000);
    expect_reg("R10 rearm attr", 4'd8, attr_word(3'd6, 2'd1, 5'h0A, 2'd2));
    reg_wr(4'd3, 32'hF, 4'b0001);
  endtask

  task automatic t_irq;
    pulse(3'b010);
    #1 check("R11 no enable", 32'(irq), 32'h0);
    reg_wr(4'd0, 32'h2, 4'b0001);
    #1 check("R11 mbe enabled", 32'(irq), 32'h1);
    reg_wr(4'd0, 32'h5, 4'b0001);
    #1 check("R11 other enables", 32'(irq), 32'h0);
    reg_wr(4'd0, 32'h7, 4'b0001);
    pulse(3'b010);
    reg_wr(4'd3, 32'h2, 4'b0001);
    expect_reg("R11 mme only left", 4'd3, 32'h8);
    #1 check("R11 mme no irq", 32'(irq), 32'h0);
    reg_wr(4'd3, 32'hF, 4'b0001);
    reg_wr(4'd0, 32'h0, 4'b0001);
  endtask

  task automatic t_full_range;
    reg_wr(4'd2, 32'h0000_FF00, 4'b0011);
    repeat (254) pulse(3'b001);
    expect_reg("R3 cnt 254", 4'd2, 32'h0000_FFFE);
    expect_reg("R3 no flag at 254", 4'd3, 32'h0);
    pulse(3'b001);
    expect_reg("R4 wrap at 255", 4'd2, 32'h0000_FF00);
    expect_reg("R4 flag at 255", 4'd3, 32'h1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_threshold();
    t_classes();
    t_disable();
    t_capture();
    t_irq();
    t_full_range();
    finish_run();
  end
endmodule